// File: doc/BRIEF.md
# Multi-Page-Size Associative Translation Lookup

This block holds a fully associative translation buffer with a parameterised number of entries (64 by default) and resolves one virtual-address lookup per request. Every entry has its own page size, so every entry uses its own compare mask. An entry also carries a context number, or it can be marked global so that any context matches. Data accesses pick the primary, the secondary or the nucleus context. Instruction fetches pick a context from the trap level.

Each hit is classified. A clean hit returns a physical address and read, write or execute permission, and sets the entry's used flag. A hit can instead raise a data fault, an instruction fault or a write-protection exception. No hit at all raises a miss. A fault loads a status register that records overflow, and also loads a fault-address register. Both faults and misses load a tag-access register that software uses to refill the buffer.

Entries are loaded through a single write port. A status-read strobe clears the status valid bit.

Top module: `mmu_tlb_lookup`

## Requirements
- R1: A lookup presented with `lkValid` high produces `rspValid` on the next clock, with `rspExc` encoded as 0 none, 1 data miss, 2 data fault, 3 data protection, 4 instruction miss, 5 instruction fault. `rspHit` is high only when `rspExc` is 0.
- R2: The page size in entry data bits 62:61 sets the compare mask: 0 ignores address bits 12:0, 1 ignores bits 15:0, 2 ignores bits 18:0 and 3 ignores bits 21:0.
- R3: An entry matches only when its valid bit (data bit 63) is set, its masked tag equals the masked address, and either its global bit (data bit 0) is set or tag bits 12:0 equal the selected context.
- R4: On a translated hit, `rspPa` takes entry data bits 40:13 where the mask keeps bits and address bits where the mask clears them, with bits 12:0 forced to zero. With translation off, `rspPa` is address bits 40:0.
- R5: `lkKind` is 0 load, 1 store, 2 no-fault load, 3 fetch. A data access uses `lkCtxSel` 0 for the primary context, 1 for the secondary context and 2 for context 0 (nucleus). A fetch uses the primary context when `trapLvlNz` is low and context 0 otherwise. A fetch bypasses translation when `redState` is high or `iXlateEn` is low. A data access bypasses translation when `dXlateEn` is low.
- R6: On a hit, several fault conditions are checked. A user access to a page whose privileged bit (data bit 2) is set is a privilege fault. A no-fault load to a page whose side-effect bit (data bit 59) is set is a fault. A load or store to a page whose no-fault-only bit (data bit 60) is set is a fault. Any of these gives code 2 and may occur together. A fetch checks privilege only and gives code 5.
- R7: A store that hits an entry whose writable bit (data bit 1) is clear, and that raises no R6 fault, gives code 3.
- R8: A clean data hit grants read permission, plus write permission when the writable bit is set. A fetch grants execute permission only. A clean hit sets that entry's bit in `usedMask`. Any exception grants no permission. Bypass grants read and write for data, and execute for a fetch.
- R9: A fault (code 2, 3 or 5) loads `statusReg` as follows:
  - bit 0 valid = 1
  - bit 1 overflow = the previous bit 0
  - bit 2 = `privMode`
  - bit 3 = store
  - bit 4 = no-fault load
  - bits 6:5 context kind (0 primary, 1 secondary, 2 nucleus)
  - bit 7 privilege fault
  - bit 8 side-effect fault
  - bit 9 no-fault-only fault

  The fault also loads `faultAddr` with the address.
- R10: A fault or a miss loads `tagAccess` with address bits 63:13 above the selected 13-bit context. A miss leaves `statusReg` and `faultAddr` unchanged.
- R11: When several entries match, the lowest-numbered entry supplies the result.
- R12: The write port loads the tag and data at `wrIdx` and clears that entry's used bit. A `stRdClr` pulse clears status bit 0, so the next fault does not set overflow. A fault in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 6 | Entry index to write |
| wrTag | input | 64 | Tag: virtual bits 63:13, context 12:0 |
| wrData | input | 64 | Entry data (layout in R2 to R8) |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 64 | Virtual address |
| lkKind | input | 2 | Access kind |
| lkUser | input | 1 | User-mode access |
| lkCtxSel | input | 2 | Data context select |
| primaryCtx | input | 13 | Primary context |
| secondaryCtx | input | 13 | Secondary context |
| trapLvlNz | input | 1 | Trap level above zero |
| redState | input | 1 | Reset/error state (fetch bypass) |
| dXlateEn | input | 1 | Data translation enable |
| iXlateEn | input | 1 | Fetch translation enable |
| privMode | input | 1 | Processor privileged |
| stRdClr | input | 1 | Status-read strobe |
| rspValid | output | 1 | Result valid |
| rspHit | output | 1 | Translation succeeded |
| rspExc | output | 3 | Exception code |
| rspPa | output | 41 | Physical address |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspExec | output | 1 | Execute permitted |
| statusReg | output | 10 | Fault status |
| faultAddr | output | 64 | Fault address |
| tagAccess | output | 64 | Tag-access value |
| usedMask | output | 64 | Per-entry used flags |

## Verification
Every result of a lookup is due exactly one clock after the edge that samples `lkValid`. This covers the response fields as well as the status, fault-address, tag-access and used updates. A driver task queues the expected response when it raises the request. A monitor compares the response on the falling edge that follows that result edge, so it never samples the edge on which outputs change. Register checks run when the driver returns, which is that same falling edge, and a miss is checked against the status value captured before it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 64;
  localparam int PA_W       = 41;
  localparam int CTX_W      = 13;
  localparam int BASE_SHIFT = 13;
  localparam int ST_W       = 10;

  typedef enum logic [1:0] {
    K_LOAD = 2'd0, K_STORE = 2'd1, K_NFLOAD = 2'd2, K_FETCH = 2'd3
  } accKind_e;

  typedef enum logic [2:0] {
    EX_NONE = 3'd0, EX_DMISS = 3'd1, EX_DFAULT = 3'd2,
    EX_DPROT = 3'd3, EX_IMISS = 3'd4, EX_IFAULT = 3'd5
  } excCode_e;

  // entry data bit positions
  localparam int E_VALID = 63;
  localparam int E_SZ_HI = 62;
  localparam int E_SZ_LO = 61;
  localparam int E_NFO   = 60;
  localparam int E_SIDE  = 59;
  localparam int E_PRIV  = 2;
  localparam int E_WR    = 1;
  localparam int E_GLB   = 0;

  // status bit positions
  localparam int S_VALID   = 0;
  localparam int S_OVER    = 1;
  localparam int S_PRIV    = 2;
  localparam int S_WRITE   = 3;
  localparam int S_NF      = 4;
  localparam int S_CTX_LO  = 5;
  localparam int S_CTX_HI  = 6;
  localparam int S_FT_PRIV = 7;
  localparam int S_FT_SIDE = 8;
  localparam int S_FT_NFO  = 9;

  typedef struct packed {
    logic            capture;
    logic            ldStatus;
    logic            clrValid;
    logic            ldFaultAddr;
    logic            ldTagAccess;
    logic            setUsed;
    logic [ST_W-1:0] statusVal;
  } tlbStrobe_t;

  typedef struct packed {
    logic isGlobal;
    logic priv;
    logic writable;
    logic sideEffect;
    logic nfoOnly;
  } hitAttr_t;

  // compare mask: page size code n ignores the low 13+3n address bits
  function automatic logic [VA_W-1:0] sizeMask(input logic [1:0] sz);
    logic [5:0] shamt;
    shamt = 6'(BASE_SHIFT) + 6'(sz) * 6'd3;
    return {VA_W{1'b1}} << shamt;
  endfunction
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [VA_W-1:0]        wrTag,
  input  logic [VA_W-1:0]        wrData,
  input  logic [VA_W-1:0]        lkVa,
  input  logic [CTX_W-1:0]       lkCtx,
  input  logic                   bypass,
  input  tlbStrobe_t             strb,
  output logic                   hitAny,
  output hitAttr_t               hitAttr,
  output logic [PA_W-1:0]        rspPa,
  output logic [ST_W-1:0]        statusQ,
  output logic [VA_W-1:0]        faultAddrQ,
  output logic [VA_W-1:0]        tagAccessQ,
  output logic [NUM_ENTRIES-1:0] usedQ
);
  localparam logic [VA_W-1:0] PA_KEEP =
    ((VA_W'(1) << PA_W) - VA_W'(1)) & ~((VA_W'(1) << BASE_SHIFT) - VA_W'(1));

  logic [VA_W-1:0]        tagMem  [NUM_ENTRIES];
  logic [VA_W-1:0]        entData [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       hitIdx;
  logic [VA_W-1:0]        hitData;
  logic [VA_W-1:0]        hitMask;
  logic [VA_W-1:0]        paWide;
  logic [PA_W-1:0]        paNext;

  // entry storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagMem[i]  <= '0;
        entData[i] <= '0;
      end
    end else if (wrEn) begin
      tagMem[wrIdx]  <= wrTag;
      entData[wrIdx] <= wrData;
    end
  end

  // per-entry compare with its own page-size mask
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [VA_W-1:0] entMask;
    logic            ctxOk;
    assign entMask     = sizeMask(entData[g][E_SZ_HI:E_SZ_LO]);
    assign ctxOk       = entData[g][E_GLB] || (tagMem[g][CTX_W-1:0] == lkCtx);
    assign matchVec[g] = entData[g][E_VALID] && ctxOk &&
                         ((tagMem[g] & entMask) == (lkVa & entMask));
  end

  // lowest index wins
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign hitData = entData[hitIdx];
  assign hitMask = sizeMask(hitData[E_SZ_HI:E_SZ_LO]);
  assign paWide  = ((hitData & hitMask) | (lkVa & ~hitMask)) & PA_KEEP;
  assign paNext  = bypass ? lkVa[PA_W-1:0] : paWide[PA_W-1:0];

  assign hitAttr.isGlobal   = hitData[E_GLB];
  assign hitAttr.priv       = hitData[E_PRIV];
  assign hitAttr.writable   = hitData[E_WR];
  assign hitAttr.sideEffect = hitData[E_SIDE];
  assign hitAttr.nfoOnly    = hitData[E_NFO];

  // used flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedQ <= '0;
    end else begin
      if (strb.setUsed) usedQ[hitIdx] <= 1'b1;
      if (wrEn)         usedQ[wrIdx]  <= 1'b0;
    end
  end

  // status, fault address, tag access, response address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ    <= '0;
      faultAddrQ <= '0;
      tagAccessQ <= '0;
      rspPa      <= '0;
    end else begin
      if (strb.ldStatus)      statusQ          <= strb.statusVal;
      else if (strb.clrValid) statusQ[S_VALID] <= 1'b0;
      if (strb.ldFaultAddr)   faultAddrQ       <= lkVa;
      if (strb.ldTagAccess)   tagAccessQ       <= {lkVa[VA_W-1:CTX_W], lkCtx};
      if (strb.capture)       rspPa            <= paNext;
    end
  end
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [1:0]       lkKind,
  input  logic             lkUser,
  input  logic [1:0]       lkCtxSel,
  input  logic [CTX_W-1:0] primaryCtx,
  input  logic [CTX_W-1:0] secondaryCtx,
  input  logic             trapLvlNz,
  input  logic             redState,
  input  logic             dXlateEn,
  input  logic             iXlateEn,
  input  logic             privMode,
  input  logic             stRdClr,
  input  logic             hitAny,
  input  hitAttr_t         hitAttr,
  input  logic [ST_W-1:0]  statusQ,
  output logic [CTX_W-1:0] lkCtx,
  output logic             bypass,
  output tlbStrobe_t       strb,
  output logic             rspValid,
  output logic             rspHit,
  output logic [2:0]       rspExc,
  output logic             rspRead,
  output logic             rspWrite,
  output logic             rspExec
);
  accKind_e  kind;
  excCode_e  excNext;
  logic      isFetch;
  logic [1:0] ctxKind;
  logic      privF, sideF, nfoF, anyF, protF;
  logic      active, fault, miss, clean;
  logic      rdNext, wrNext, exNext;
  logic [ST_W-1:0] statusVal;

  assign kind    = accKind_e'(lkKind);
  assign isFetch = (kind == K_FETCH);

  // context selection
  always_comb begin
    if (isFetch) begin
      ctxKind = trapLvlNz ? 2'd2 : 2'd0;
      lkCtx   = trapLvlNz ? '0 : primaryCtx;
    end else begin
      case (lkCtxSel)
        2'd0:    begin ctxKind = 2'd0; lkCtx = primaryCtx;   end
        2'd1:    begin ctxKind = 2'd1; lkCtx = secondaryCtx; end
        default: begin ctxKind = 2'd2; lkCtx = '0;           end
      endcase
    end
  end

  assign bypass = isFetch ? (!iXlateEn || redState) : !dXlateEn;

  // fault classification
  assign privF = hitAny && hitAttr.priv && lkUser;
  assign sideF = hitAny && (kind == K_NFLOAD) && hitAttr.sideEffect;
  assign nfoF  = hitAny && ((kind == K_LOAD) || (kind == K_STORE)) && hitAttr.nfoOnly;
  assign anyF  = privF || sideF || nfoF;
  assign protF = hitAny && !anyF && (kind == K_STORE) && !hitAttr.writable;

  assign active = lkValid && !bypass;
  assign fault  = active && (anyF || protF);
  assign miss   = active && !hitAny;
  assign clean  = active && hitAny && !anyF && !protF;

  always_comb begin
    if (!active)   excNext = EX_NONE;
    else if (miss) excNext = isFetch ? EX_IMISS : EX_DMISS;
    else if (anyF) excNext = isFetch ? EX_IFAULT : EX_DFAULT;
    else if (protF) excNext = EX_DPROT;
    else           excNext = EX_NONE;
  end

  always_comb begin
    rdNext = 1'b0;
    wrNext = 1'b0;
    exNext = 1'b0;
    if (lkValid && (bypass || clean)) begin
      if (isFetch) exNext = 1'b1;
      else begin
        rdNext = 1'b1;
        wrNext = bypass || hitAttr.writable;
      end
    end
  end

  always_comb begin
    statusVal                    = '0;
    statusVal[S_VALID]           = 1'b1;
    statusVal[S_OVER]            = statusQ[S_VALID];
    statusVal[S_PRIV]            = privMode;
    statusVal[S_WRITE]           = (kind == K_STORE);
    statusVal[S_NF]              = (kind == K_NFLOAD);
    statusVal[S_CTX_HI:S_CTX_LO] = ctxKind;
    statusVal[S_FT_PRIV]         = privF;
    statusVal[S_FT_SIDE]         = sideF;
    statusVal[S_FT_NFO]          = nfoF;
  end

  always_comb begin
    strb.capture     = lkValid;
    strb.ldStatus    = fault;
    strb.clrValid    = stRdClr;
    strb.ldFaultAddr = fault;
    strb.ldTagAccess = fault || miss;
    strb.setUsed     = clean;
    strb.statusVal   = statusVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspExc   <= 3'd0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= lkValid && (excNext == EX_NONE);
      rspExc   <= excNext;
      rspRead  <= rdNext;
      rspWrite <= wrNext;
      rspExec  <= exNext;
    end
  end
endmodule

// File: rtl/mmu_tlb_lookup.sv
module mmu_tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [VA_W-1:0]        wrTag,
  input  logic [VA_W-1:0]        wrData,
  input  logic                   lkValid,
  input  logic [VA_W-1:0]        lkVa,
  input  logic [1:0]             lkKind,
  input  logic                   lkUser,
  input  logic [1:0]             lkCtxSel,
  input  logic [CTX_W-1:0]       primaryCtx,
  input  logic [CTX_W-1:0]       secondaryCtx,
  input  logic                   trapLvlNz,
  input  logic                   redState,
  input  logic                   dXlateEn,
  input  logic                   iXlateEn,
  input  logic                   privMode,
  input  logic                   stRdClr,
  output logic                   rspValid,
  output logic                   rspHit,
  output logic [2:0]             rspExc,
  output logic [PA_W-1:0]        rspPa,
  output logic                   rspRead,
  output logic                   rspWrite,
  output logic                   rspExec,
  output logic [ST_W-1:0]        statusReg,
  output logic [VA_W-1:0]        faultAddr,
  output logic [VA_W-1:0]        tagAccess,
  output logic [NUM_ENTRIES-1:0] usedMask
);
  tlbStrobe_t       strb;
  hitAttr_t         hitAttr;
  logic             hitAny;
  logic             bypass;
  logic [CTX_W-1:0] lkCtx;

  tlb_control u_ctrl (
    .clk, .rstN, .lkValid, .lkKind, .lkUser, .lkCtxSel,
    .primaryCtx, .secondaryCtx, .trapLvlNz, .redState, .dXlateEn, .iXlateEn,
    .privMode, .stRdClr, .hitAny, .hitAttr, .statusQ(statusReg),
    .lkCtx, .bypass, .strb, .rspValid, .rspHit, .rspExc,
    .rspRead, .rspWrite, .rspExec
  );

  tlb_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk, .rstN, .wrEn, .wrIdx, .wrTag, .wrData, .lkVa, .lkCtx, .bypass, .strb,
    .hitAny, .hitAttr, .rspPa, .statusQ(statusReg), .faultAddrQ(faultAddr),
    .tagAccessQ(tagAccess), .usedQ(usedMask)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        lkValid,
  input logic [1:0]  lkKind,
  input logic        dXlateEn,
  input logic        stRdClr,
  input logic        rspValid,
  input logic        rspHit,
  input logic [2:0]  rspExc,
  input logic [40:0] rspPa,
  input logic        rspRead,
  input logic        rspWrite,
  input logic        rspExec,
  input logic [9:0]  statusReg
);
  logic isFault, isMiss;
  assign isFault = rspValid && (rspExc == 3'd2 || rspExc == 3'd3 || rspExc == 3'd5);
  assign isMiss  = rspValid && (rspExc == 3'd1 || rspExc == 3'd4);

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid); // R1
  AST_HIT_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspExc == 3'd0)); // R1
  AST_NO_PERM_ON_EXC: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspExc != 3'd0) |-> !(rspRead || rspWrite || rspExec)); // R8
  AST_FAULT_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    isFault |-> statusReg[0]); // R9
  AST_OVERFLOW_ON_REFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (isFault && $past(statusReg[0])) |-> statusReg[1]); // R9
  AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (isMiss && !$past(stRdClr)) |-> $stable(statusReg)); // R10
  AST_PROT_ONLY_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspExc == 3'd3) |-> ($past(lkKind) == 2'd1)); // R7
  AST_PA_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && $past(lkKind) != 2'd3 && $past(dXlateEn)) |-> (rspPa[12:0] == 13'd0)); // R4
endmodule

bind mmu_tlb_lookup tlb_checker u_chk (
  .clk, .rstN, .lkValid, .lkKind, .dXlateEn, .stRdClr, .rspValid, .rspHit,
  .rspExc, .rspPa, .rspRead, .rspWrite, .rspExec, .statusReg
);

// File: tb/test_mmu_tlb_lookup.sv
module test_mmu_tlb_lookup;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [63:0] wrTag = '0, wrData = '0;
  logic        lkValid = 1'b0;
  logic [63:0] lkVa = '0;
  logic [1:0]  lkKind = '0;
  logic        lkUser = 1'b0;
  logic [1:0]  lkCtxSel = '0;
  logic [12:0] primaryCtx = 13'h123, secondaryCtx = 13'h045;
  logic        trapLvlNz = 1'b0, redState = 1'b0;
  logic        dXlateEn = 1'b0, iXlateEn = 1'b1, privMode = 1'b0, stRdClr = 1'b0;
  logic        rspValid, rspHit, rspRead, rspWrite, rspExec;
  logic [2:0]  rspExc;
  logic [40:0] rspPa;
  logic [9:0]  statusReg;
  logic [63:0] faultAddr, tagAccess, usedMask;

  mmu_tlb_lookup i_mmu_tlb_lookup (
    .clk, .rstN, .wrEn, .wrIdx, .wrTag, .wrData, .lkValid, .lkVa, .lkKind,
    .lkUser, .lkCtxSel, .primaryCtx, .secondaryCtx, .trapLvlNz, .redState,
    .dXlateEn, .iXlateEn, .privMode, .stRdClr, .rspValid, .rspHit, .rspExc,
    .rspPa, .rspRead, .rspWrite, .rspExec, .statusReg, .faultAddr,
    .tagAccess, .usedMask
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [2:0]  exc;
    logic        ok;
    logic [40:0] pa;
    logic [2:0]  perm;
    string       req;
  } expItem_t;
  expItem_t expQ[$];
  expItem_t cur;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkData(input logic [1:0] sz, input logic glb,
      input logic priv, input logic wr, input logic se, input logic nfo,
      input logic [40:0] pa);
    logic [63:0] d;
    d        = '0;
    d[63]    = 1'b1;
    d[62:61] = sz;
    d[60]    = nfo;
    d[59]    = se;
    d[40:13] = pa[40:13];
    d[2]     = priv;
    d[1]     = wr;
    d[0]     = glb;
    return d;
  endfunction

  function automatic expItem_t mkExp(input logic [2:0] exc, input logic [40:0] pa,
                                     input logic [2:0] perm, input string req);
    expItem_t e;
    e.exc = exc; e.ok = (exc == 3'd0); e.pa = pa; e.perm = perm; e.req = req;
    return e;
  endfunction

  task automatic writeEntry(input int idx, input logic [63:0] tag, input logic [63:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'(idx); wrTag = tag; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [1:0] kind, input logic [63:0] va, input logic user,
                        input logic [1:0] sel, input expItem_t e);
    @(negedge clk);
    lkKind = kind; lkVa = va; lkUser = user; lkCtxSel = sel; lkValid = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic clearStatus();
    @(negedge clk);
    stRdClr = 1'b1;
    @(negedge clk);
    stRdClr = 1'b0;
  endtask

  // monitor: result due one cycle after the sampled request
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "unexpected response", 64'(rspExc), 64'd0);
      end else begin
        cur = expQ.pop_front();
        check(rspExc == cur.exc, cur.req, "code", 64'(rspExc), 64'(cur.exc));
        check(rspHit == cur.ok, cur.req, "hit", 64'(rspHit), 64'(cur.ok));
        check({rspRead, rspWrite, rspExec} == cur.perm, cur.req, "perm",
              64'({rspRead, rspWrite, rspExec}), 64'(cur.perm));
        if (cur.ok) check(rspPa == cur.pa, cur.req, "pa", 64'(rspPa), 64'(cur.pa));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(rspValid == 1'b0, "R1", "reset rspValid", 64'(rspValid), 64'd0);
    check(statusReg == 10'd0, "R9", "reset status", 64'(statusReg), 64'd0);
    check(usedMask == 64'd0, "R8", "reset used", usedMask, 64'd0);

    // R4 / R8: data bypass passes address bits 40:0 with read+write
    lookup(2'd0, 64'hFFFF_FFFF_1234_5678, 1'b1, 2'd0,
           mkExp(3'd0, 41'h1FF_1234_5678, 3'b110, "R4"));

    dXlateEn = 1'b1;
    writeEntry(0, 64'h4000_0123, mkData(2'd0, 0, 0, 0, 0, 0, 41'h0AB_CDE0_2000));
    writeEntry(1, 64'h8000_0123, mkData(2'd0, 0, 1, 0, 0, 1, 41'h000_0011_0000));
    writeEntry(2, 64'h1_00C0_0045, mkData(2'd3, 0, 0, 0, 1, 0, 41'h001_2340_0000));
    writeEntry(3, 64'h5_0007, mkData(2'd1, 1, 0, 1, 0, 0, 41'h000_0077_0000));
    writeEntry(4, 64'h0100_0123, mkData(2'd2, 0, 0, 0, 0, 0, 41'h000_0200_0000));
    writeEntry(6, 64'h9000_0123, mkData(2'd0, 0, 0, 0, 0, 0, 41'h000_0666_0000));
    writeEntry(5, 64'h9000_0123, mkData(2'd0, 0, 0, 0, 0, 0, 41'h000_0555_0000));
    writeEntry(7, 64'hA000_0000, mkData(2'd0, 0, 1, 0, 0, 0, 41'h000_0A00_0000));

    // R1 / R8: clean read hit on 8K page, low bits dropped
    lookup(2'd0, 64'h4000_0ABC, 1'b1, 2'd0, mkExp(3'd0, 41'h0AB_CDE0_2000, 3'b100, "R8"));
    check(usedMask[0] == 1'b1, "R8", "used bit 0", 64'(usedMask[0]), 64'd1);

    // R7: store to read-only page -> protection
    lookup(2'd1, 64'h4000_0ABC, 1'b1, 2'd0, mkExp(3'd3, '0, 3'b000, "R7"));
    check(statusReg == 10'h009, "R9", "status after prot", 64'(statusReg), 64'h009);
    check(faultAddr == 64'h4000_0ABC, "R9", "fault addr", faultAddr, 64'h4000_0ABC);
    check(tagAccess == 64'h4000_0123, "R10", "tag access", tagAccess, 64'h4000_0123);

    // R6 / R9: privilege + no-fault-only together, overflow since valid was set
    lookup(2'd0, 64'h8000_0000, 1'b1, 2'd0, mkExp(3'd2, '0, 3'b000, "R6"));
    check(statusReg == 10'h283, "R9", "status overflow", 64'(statusReg), 64'h283);

    // R12: status-read clears valid
    clearStatus();
    check(statusReg == 10'h282, "R12", "status cleared", 64'(statusReg), 64'h282);

    // R6 / R9 / R12: no-fault load to side-effect 4M page, secondary ctx, no overflow
    privMode = 1'b1;
    lookup(2'd2, 64'h1_00C1_2345, 1'b0, 2'd1, mkExp(3'd2, '0, 3'b000, "R6"));
    check(statusReg == 10'h135, "R12", "status no overflow", 64'(statusReg), 64'h135);
    check(tagAccess == 64'h1_00C1_2045, "R10", "tag access sec", tagAccess, 64'h1_00C1_2045);
    privMode = 1'b0;

    // R2 / R4: 4M page translation
    lookup(2'd0, 64'h1_00C1_2345, 1'b0, 2'd1, mkExp(3'd0, 41'h001_2341_2000, 3'b100, "R2"));

    // R3 / R10: context mismatch -> miss, status and fault addr unchanged
    lookup(2'd0, 64'h1_00C1_2345, 1'b0, 2'd0, mkExp(3'd1, '0, 3'b000, "R10"));
    check(statusReg == 10'h135, "R10", "miss keeps status", 64'(statusReg), 64'h135);
    check(faultAddr == 64'h1_00C1_2345, "R10", "miss keeps fault addr", faultAddr, 64'h1_00C1_2345);
    check(tagAccess == 64'h1_00C1_2123, "R10", "miss tag access", tagAccess, 64'h1_00C1_2123);

    // R3 / R2: global 64K writable page with different context
    lookup(2'd1, 64'h5_ABCD, 1'b1, 2'd0, mkExp(3'd0, 41'h000_0077_A000, 3'b110, "R3"));

    // R2: 512K boundary
    lookup(2'd0, 64'h0107_FFFF, 1'b0, 2'd0, mkExp(3'd0, 41'h000_0207_E000, 3'b100, "R2"));
    lookup(2'd0, 64'h0108_0000, 1'b0, 2'd0, mkExp(3'd1, '0, 3'b000, "R2"));

    // R11: two matching entries, lowest index wins
    lookup(2'd0, 64'h9000_0000, 1'b0, 2'd0, mkExp(3'd0, 41'h000_0555_0000, 3'b100, "R11"));
    check(usedMask[5] == 1'b1, "R11", "used 5", 64'(usedMask[5]), 64'd1);
    check(usedMask[6] == 1'b0, "R11", "used 6", 64'(usedMask[6]), 64'd0);

    // R6: no-fault load to no-fault-only page by kernel is clean
    lookup(2'd2, 64'h8000_0000, 1'b0, 2'd0, mkExp(3'd0, 41'h000_0011_0000, 3'b100, "R6"));

    // R5: nucleus data context reaches context-0 entry
    lookup(2'd0, 64'hA000_0010, 1'b0, 2'd2, mkExp(3'd0, 41'h000_0A00_0000, 3'b100, "R5"));

    // R5 / R8: kernel fetch at trap level > 0 uses context 0, execute only
    trapLvlNz = 1'b1;
    lookup(2'd3, 64'hA000_0000, 1'b0, 2'd0, mkExp(3'd0, 41'h000_0A00_0000, 3'b001, "R5"));

    // R5 / R10: fetch at trap level 0 uses primary -> instruction miss
    trapLvlNz = 1'b0;
    lookup(2'd3, 64'hA000_0000, 1'b1, 2'd0, mkExp(3'd4, '0, 3'b000, "R5"));
    check(tagAccess == 64'hA000_0123, "R10", "fetch miss tag", tagAccess, 64'hA000_0123);

    // R6 / R9: user fetch of privileged page -> instruction fault, nucleus ctx kind
    clearStatus();
    trapLvlNz = 1'b1;
    lookup(2'd3, 64'hA000_0000, 1'b1, 2'd0, mkExp(3'd5, '0, 3'b000, "R6"));
    check(statusReg == 10'h0C1, "R9", "fetch fault status", 64'(statusReg), 64'h0C1);
    check(faultAddr == 64'hA000_0000, "R9", "fetch fault addr", faultAddr, 64'hA000_0000);
    trapLvlNz = 1'b0;

    // R5: reset/error state bypasses fetch translation
    redState = 1'b1;
    lookup(2'd3, 64'h3_0000_1234, 1'b1, 2'd0, mkExp(3'd0, 41'h003_0000_1234, 3'b001, "R5"));
    redState = 1'b0;

    // R12: overwrite entry 2 as invalid -> miss, used bit cleared
    writeEntry(2, 64'h1_00C0_0045, 64'd0);
    check(usedMask[2] == 1'b0, "R12", "used cleared by write", 64'(usedMask[2]), 64'd0);
    lookup(2'd0, 64'h1_00C1_2345, 1'b0, 2'd1, mkExp(3'd1, '0, 3'b000, "R12"));

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R1", "pending responses", 64'(expQ.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule